// File: doc/BRIEF.md
# Processor Run-Control Debug Unit

This block sits between a host command link and a simple single-cycle processor core and decides, every clock, whether the core is allowed to retire an instruction. The host can start the core, stop it, or let it run for a given number of instructions. While the core is halted, the host can inspect and change the program counter, fetch general registers in two phases, and read 32-bit memory words. A single breakpoint register halts the core when its program counter matches.

The unit also counts clock cycles spent in the running state and retired instructions. These counters are readable by the host. Characters the core prints are queued in a small console FIFO that the host drains. When that FIFO fills, the core is held. The cycle count keeps climbing during this hold, but the instruction count does not. A status output shows whether the core is running and why it last halted.

The host issues one command per cycle on the command port. Commands that return data answer on the response port one cycle later.

Top module: `run_ctl_unit`

## Requirements
- R1: After reset the core is halted: `core_en` is 0, `stat_running` is 0, `stat_cause` is 0, no response is pending, the console FIFO is empty, and both counters read 0.
- R2: Command code 1 (start) issued while halted raises `stat_running` and `core_en` in the next cycle. Command code 2 (stop) issued while running halts the core with `stat_cause` = 1. The stop takes effect at the edge that consumes it, so an instruction retiring in that same cycle still completes.
- R3: Command code 3 (step) with count N in `cmd_arg` lets exactly N instructions retire, then halts the core with `stat_cause` = 2. A count of 0 leaves the core halted and the PC unchanged.
- R4: Command code 4 returns the current `core_pc` one cycle later, in any state. Command code 5 pulses `pc_wr_en` with `pc_wr_data` = `cmd_arg` only while halted; while running it is ignored.
- R5: Command code 6 requests a register read. It drives `reg_rd_en` and `reg_rd_idx` = `cmd_arg[4:0]` in the same cycle and captures `reg_rd_data`. Command code 7 later returns the captured word. While running, code 6 is ignored and the captured word is kept.
- R6: Command code 8 reads the memory word at address `cmd_arg` while halted: `mem_rd_en` is driven in the same cycle and `mem_rd_data` is returned one cycle later. While running, code 8 is ignored and produces no response.
- R7: Command codes 9 and 10 return the cycle counter and the retired-instruction counter, zero-extended. The cycle counter advances on every clock the core is running, including stalled clocks. The instruction counter advances only on `core_retire`. Both wrap modulo 2^CNT_W.
- R8: Command code 11 loads the breakpoint with `cmd_arg` and arms it. Command code 12 disarms it. When the core is running and `core_pc` equals an armed breakpoint, `core_en` drops, the instruction at that address does not retire, and the core halts with `stat_cause` = 3. This holds during a step as well.
- R9: A start or step issued while `core_pc` sits on the armed breakpoint lets the first instruction retire. Later matches halt the core again.
- R10: While the console FIFO holds CON_DEPTH entries, `core_en` is 0 even though the core is running. Popping one entry lets the core proceed.
- R11: Console bytes leave on `out_data` in the order they were pushed, with `out_valid` showing that the FIFO is not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Host command strobe |
| cmd_op | input | 4 | Host command code |
| cmd_arg | input | XLEN | Command argument (count, PC, index, address) |
| rsp_valid | output | 1 | Response strobe, one cycle after a reading command |
| rsp_data | output | XLEN | Response word |
| stat_running | output | 1 | Core is in the running state |
| stat_cause | output | 2 | Last halt reason: 0 reset, 1 stop, 2 step done, 3 breakpoint |
| core_en | output | 1 | Core may retire an instruction this cycle |
| core_pc | input | XLEN | Core program counter |
| core_retire | input | 1 | Core retired an instruction this cycle |
| pc_wr_en | output | 1 | PC overwrite strobe |
| pc_wr_data | output | XLEN | New PC value |
| reg_rd_en | output | 1 | Register read strobe |
| reg_rd_idx | output | RIDX_W | Register index |
| reg_rd_data | input | XLEN | Register word, valid in the strobe cycle |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | XLEN | Memory address |
| mem_rd_data | input | XLEN | Memory word, valid in the strobe cycle |
| con_push | input | 1 | Core pushes a console byte |
| con_data | input | CON_W | Console byte |
| out_valid | output | 1 | Console FIFO not empty |
| out_data | output | CON_W | Oldest console byte |
| out_pop | input | 1 | Host removes the oldest console byte |

## Verification
A corrupt run state shows up within one cycle, as `core_en` asserted while halted or held low while running. It also shows up after the next step or breakpoint, as a PC read that lands on the wrong address. A step counter that is off by one moves the read-back PC by exactly four bytes. A breakpoint skip flag that stays set lets the core run past the match, and the next status read shows the wrong halt cause. Counter faults appear as exact cycle or instruction deltas that disagree with the known run length. A FIFO pointer fault shows at once as a retire count other than CON_DEPTH during a stall, or as bytes popped out of order.

// File: rtl/rcu_pkg.sv
package rcu_pkg;

    typedef enum logic [3:0] {
        OP_NOP     = 4'd0,
        OP_START   = 4'd1,
        OP_STOP    = 4'd2,
        OP_STEP    = 4'd3,
        OP_RD_PC   = 4'd4,
        OP_WR_PC   = 4'd5,
        OP_REG_REQ = 4'd6,
        OP_REG_GET = 4'd7,
        OP_RD_MEM  = 4'd8,
        OP_RD_CYC  = 4'd9,
        OP_RD_INS  = 4'd10,
        OP_SET_BP  = 4'd11,
        OP_CLR_BP  = 4'd12
    } host_op_e;

    typedef enum logic [1:0] {
        HALT_RESET = 2'd0,
        HALT_STOP  = 2'd1,
        HALT_STEP  = 2'd2,
        HALT_BREAK = 2'd3
    } halt_cause_e;

endpackage

// File: rtl/rcu_run_ctrl.sv
module rcu_run_ctrl
    import rcu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go_start,
    input  logic            go_stop,
    input  logic            go_step,
    input  logic [XLEN-1:0] step_cnt,
    input  logic            bp_set,
    input  logic            bp_clr,
    input  logic [XLEN-1:0] bp_val,
    input  logic [XLEN-1:0] core_pc,
    input  logic            core_retire,
    input  logic            con_full,
    output logic            core_en,
    output logic            bp_hit,
    output logic            running,
    output logic [1:0]      cause
);

    typedef struct packed {
        logic            run;
        logic            step_mode;
        logic [XLEN-1:0] step_left;
        halt_cause_e     cause;
        logic [XLEN-1:0] bp_pc;
        logic            bp_armed;
        logic            skip;
    } ctrl_t;

    localparam logic [XLEN-1:0] ONE = XLEN'(1);

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d  = ctrl_q;
        bp_hit  = ctrl_q.run && ctrl_q.bp_armed && !ctrl_q.skip && (core_pc == ctrl_q.bp_pc);
        core_en = ctrl_q.run && !con_full && !bp_hit;

        if (bp_set) begin
            ctrl_d.bp_pc    = bp_val;
            ctrl_d.bp_armed = 1'b1;
        end
        if (bp_clr) begin
            ctrl_d.bp_armed = 1'b0;
        end

        if (ctrl_q.run) begin
            if (core_retire) begin
                ctrl_d.skip = 1'b0;
                if (ctrl_q.step_mode) begin
                    ctrl_d.step_left = ctrl_q.step_left - ONE;
                    if (ctrl_q.step_left == ONE) begin
                        ctrl_d.run   = 1'b0;
                        ctrl_d.cause = HALT_STEP;
                    end
                end
            end
            if (bp_hit) begin
                ctrl_d.run   = 1'b0;
                ctrl_d.cause = HALT_BREAK;
            end
            if (go_stop) begin
                ctrl_d.run   = 1'b0;
                ctrl_d.cause = HALT_STOP;
            end
        end else begin
            if (go_start) begin
                ctrl_d.run       = 1'b1;
                ctrl_d.step_mode = 1'b0;
                ctrl_d.skip      = 1'b1;
            end else if (go_step && (step_cnt != '0)) begin
                ctrl_d.run       = 1'b1;
                ctrl_d.step_mode = 1'b1;
                ctrl_d.step_left = step_cnt;
                ctrl_d.skip      = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign running = ctrl_q.run;
    assign cause   = ctrl_q.cause;

endmodule

// File: rtl/rcu_prof_cnt.sv
module rcu_prof_cnt #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             running,
    input  logic             retire,
    output logic [CNT_W-1:0] cyc_cnt,
    output logic [CNT_W-1:0] ins_cnt
);

    typedef struct packed {
        logic [CNT_W-1:0] cyc;
        logic [CNT_W-1:0] ins;
    } cnt_t;

    localparam logic [CNT_W-1:0] INC = CNT_W'(1);

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (running) begin
            cnt_d.cyc = cnt_q.cyc + INC;
        end
        if (retire) begin
            cnt_d.ins = cnt_q.ins + INC;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cyc_cnt = cnt_q.cyc;
    assign ins_cnt = cnt_q.ins;

endmodule

// File: rtl/rcu_con_fifo.sv
module rcu_con_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    output logic         full
);

    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW:0]             wr;
        logic [AW:0]             rd;
    } fifo_t;

    localparam logic [AW:0] STEP1 = (AW + 1)'(1);

    fifo_t fifo_d, fifo_q;
    logic  empty;

    always_comb begin
        fifo_d = fifo_q;
        empty  = (fifo_q.wr == fifo_q.rd);
        full   = (fifo_q.wr[AW] != fifo_q.rd[AW]) &&
                 (fifo_q.wr[AW-1:0] == fifo_q.rd[AW-1:0]);
        if (push && !full) begin
            fifo_d.mem[fifo_q.wr[AW-1:0]] = push_data;
            fifo_d.wr = fifo_q.wr + STEP1;
        end
        if (pop && !empty) begin
            fifo_d.rd = fifo_q.rd + STEP1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fifo_q <= '0;
        end else begin
            fifo_q <= fifo_d;
        end
    end

    assign out_valid = !empty;
    assign out_data  = fifo_q.mem[fifo_q.rd[AW-1:0]];

endmodule

// File: rtl/run_ctl_unit.sv
module run_ctl_unit
    import rcu_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int RIDX_W    = 5,
    parameter int CNT_W     = 32,
    parameter int CON_W     = 8,
    parameter int CON_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [3:0]        cmd_op,
    input  logic [XLEN-1:0]   cmd_arg,
    output logic              rsp_valid,
    output logic [XLEN-1:0]   rsp_data,
    output logic              stat_running,
    output logic [1:0]        stat_cause,
    output logic              core_en,
    input  logic [XLEN-1:0]   core_pc,
    input  logic              core_retire,
    output logic              pc_wr_en,
    output logic [XLEN-1:0]   pc_wr_data,
    output logic              reg_rd_en,
    output logic [RIDX_W-1:0] reg_rd_idx,
    input  logic [XLEN-1:0]   reg_rd_data,
    output logic              mem_rd_en,
    output logic [XLEN-1:0]   mem_rd_addr,
    input  logic [XLEN-1:0]   mem_rd_data,
    input  logic              con_push,
    input  logic [CON_W-1:0]  con_data,
    output logic              out_valid,
    output logic [CON_W-1:0]  out_data,
    input  logic              out_pop
);

    typedef struct packed {
        logic            rsp_valid;
        logic [XLEN-1:0] rsp_data;
        logic [XLEN-1:0] reg_buf;
    } host_t;

    host_t      host_d, host_q;
    host_op_e   op;
    logic       running;
    logic [1:0] cause;
    logic       bp_hit;
    logic       con_full;
    logic       go_start, go_stop, go_step, bp_set, bp_clr;
    logic [CNT_W-1:0] cyc_cnt, ins_cnt;

    assign op = host_op_e'(cmd_op);

    always_comb begin
        go_start  = cmd_valid && (op == OP_START);
        go_stop   = cmd_valid && (op == OP_STOP);
        go_step   = cmd_valid && (op == OP_STEP);
        bp_set    = cmd_valid && (op == OP_SET_BP);
        bp_clr    = cmd_valid && (op == OP_CLR_BP);
        pc_wr_en  = cmd_valid && (op == OP_WR_PC)   && !running;
        reg_rd_en = cmd_valid && (op == OP_REG_REQ) && !running;
        mem_rd_en = cmd_valid && (op == OP_RD_MEM)  && !running;
    end

    assign pc_wr_data  = cmd_arg;
    assign reg_rd_idx  = cmd_arg[RIDX_W-1:0];
    assign mem_rd_addr = cmd_arg;

    always_comb begin
        host_d           = host_q;
        host_d.rsp_valid = 1'b0;
        if (reg_rd_en) begin
            host_d.reg_buf = reg_rd_data;
        end
        if (cmd_valid) begin
            unique case (op)
                OP_RD_PC: begin
                    host_d.rsp_valid = 1'b1;
                    host_d.rsp_data  = core_pc;
                end
                OP_REG_GET: begin
                    host_d.rsp_valid = 1'b1;
                    host_d.rsp_data  = host_q.reg_buf;
                end
                OP_RD_MEM: begin
                    if (!running) begin
                        host_d.rsp_valid = 1'b1;
                        host_d.rsp_data  = mem_rd_data;
                    end
                end
                OP_RD_CYC: begin
                    host_d.rsp_valid = 1'b1;
                    host_d.rsp_data  = XLEN'(cyc_cnt);
                end
                OP_RD_INS: begin
                    host_d.rsp_valid = 1'b1;
                    host_d.rsp_data  = XLEN'(ins_cnt);
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            host_q <= '0;
        end else begin
            host_q <= host_d;
        end
    end

    assign rsp_valid    = host_q.rsp_valid;
    assign rsp_data     = host_q.rsp_data;
    assign stat_running = running;
    assign stat_cause   = cause;

    rcu_run_ctrl #(.XLEN(XLEN)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .go_start    (go_start),
        .go_stop     (go_stop),
        .go_step     (go_step),
        .step_cnt    (cmd_arg),
        .bp_set      (bp_set),
        .bp_clr      (bp_clr),
        .bp_val      (cmd_arg),
        .core_pc     (core_pc),
        .core_retire (core_retire),
        .con_full    (con_full),
        .core_en     (core_en),
        .bp_hit      (bp_hit),
        .running     (running),
        .cause       (cause)
    );

    rcu_prof_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .running (running),
        .retire  (core_retire),
        .cyc_cnt (cyc_cnt),
        .ins_cnt (ins_cnt)
    );

    rcu_con_fifo #(.W(CON_W), .DEPTH(CON_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (con_push),
        .push_data (con_data),
        .pop       (out_pop),
        .out_valid (out_valid),
        .out_data  (out_data),
        .full      (con_full)
    );

endmodule

// File: rtl/rcu_checker.sv
module rcu_checker #(
    parameter int XLEN  = 32,
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic [3:0]       cmd_op,
    input logic [XLEN-1:0]  cmd_arg,
    input logic             stat_running,
    input logic [1:0]       stat_cause,
    input logic             core_en,
    input logic             core_retire,
    input logic             pc_wr_en,
    input logic             mem_rd_en,
    input logic             rsp_valid,
    input logic             bp_hit,
    input logic             con_full,
    input logic [CNT_W-1:0] cyc_cnt,
    input logic [CNT_W-1:0] ins_cnt
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    AST_START_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 4'd1 && !stat_running) |=> stat_running); // R2

    AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 4'd2 && stat_running) |=> (!stat_running && stat_cause == 2'd1)); // R2

    AST_STEP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 4'd3 && cmd_arg == '0 && !stat_running) |=> !stat_running); // R3

    AST_WRPC_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
        pc_wr_en |-> !stat_running); // R4

    AST_MEM_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> rsp_valid); // R6

    AST_CYC_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        stat_running |=> (cyc_cnt == $past(cyc_cnt) + ONE)); // R7

    AST_INS_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
        core_retire |=> (ins_cnt == $past(ins_cnt) + ONE)); // R7

    AST_INS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !core_retire |=> $stable(ins_cnt)); // R7

    AST_BP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        bp_hit |-> !core_en); // R8

    AST_BP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        (bp_hit && !(cmd_valid && cmd_op == 4'd2)) |=> (!stat_running && stat_cause == 2'd3)); // R8

    AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        con_full |-> !core_en); // R10

endmodule

bind run_ctl_unit rcu_checker #(.XLEN(XLEN), .CNT_W(CNT_W)) i_rcu_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_op       (cmd_op),
    .cmd_arg      (cmd_arg),
    .stat_running (stat_running),
    .stat_cause   (stat_cause),
    .core_en      (core_en),
    .core_retire  (core_retire),
    .pc_wr_en     (pc_wr_en),
    .mem_rd_en    (mem_rd_en),
    .rsp_valid    (rsp_valid),
    .bp_hit       (bp_hit),
    .con_full     (con_full),
    .cyc_cnt      (cyc_cnt),
    .ins_cnt      (ins_cnt)
);

// File: tb/test_run_ctl_unit.sv
module test_run_ctl_unit;

    localparam int XLEN = 32, RIDX_W = 5, CNT_W = 8, CON_W = 8, CON_DEPTH = 4;
    localparam logic [3:0] C_START = 4'd1, C_STOP = 4'd2, C_STEP = 4'd3, C_RDPC = 4'd4,
        C_WRPC = 4'd5, C_RREQ = 4'd6, C_RGET = 4'd7, C_RMEM = 4'd8, C_RCYC = 4'd9,
        C_RINS = 4'd10, C_SETBP = 4'd11, C_CLRBP = 4'd12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic              cmd_valid = 1'b0;
    logic [3:0]        cmd_op = '0;
    logic [XLEN-1:0]   cmd_arg = '0;
    logic              rsp_valid, stat_running, core_en, pc_wr_en, reg_rd_en, mem_rd_en, out_valid;
    logic [XLEN-1:0]   rsp_data, pc_wr_data, mem_rd_addr, reg_rd_data, mem_rd_data;
    logic [1:0]        stat_cause;
    logic [RIDX_W-1:0] reg_rd_idx;
    logic [CON_W-1:0]  out_data, con_data;
    logic              out_pop = 1'b0;
    logic              core_retire, con_push;
    logic              print_on = 1'b0, bub_mode = 1'b0;
    logic [XLEN-1:0]   pc_m;
    logic [7:0]        tick;

    assign core_retire = core_en & ~(bub_mode & tick[0]);
    assign con_push    = core_retire & print_on;
    assign con_data    = pc_m[9:2];
    assign reg_rd_data = 32'hC0DE_0000 + 32'(reg_rd_idx) * 32'd3;
    assign mem_rd_data = ~mem_rd_addr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_m <= 32'h100;
            tick <= '0;
        end else begin
            tick <= tick + 8'd1;
            if (pc_wr_en) pc_m <= pc_wr_data;
            else if (core_retire) pc_m <= pc_m + 32'd4;
        end
    end

    run_ctl_unit #(.XLEN(XLEN), .RIDX_W(RIDX_W), .CNT_W(CNT_W), .CON_W(CON_W),
                   .CON_DEPTH(CON_DEPTH)) i_run_ctl_unit (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_arg(cmd_arg),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .stat_running(stat_running),
        .stat_cause(stat_cause), .core_en(core_en), .core_pc(pc_m), .core_retire(core_retire),
        .pc_wr_en(pc_wr_en), .pc_wr_data(pc_wr_data), .reg_rd_en(reg_rd_en),
        .reg_rd_idx(reg_rd_idx), .reg_rd_data(reg_rd_data), .mem_rd_en(mem_rd_en),
        .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data), .con_push(con_push),
        .con_data(con_data), .out_valid(out_valid), .out_data(out_data), .out_pop(out_pop)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // called and returns just after a falling edge
    task automatic cmd(input logic [3:0] op, input logic [31:0] arg);
        cmd_valid = 1'b1; cmd_op = op; cmd_arg = arg;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = '0; cmd_arg = '0;
    endtask

    task automatic rd(input string req, input logic [3:0] op, input logic [31:0] arg,
                      output logic [31:0] v);
        cmd(op, arg);
        chk({req, " rsp_valid"}, 32'(rsp_valid), 32'd1);
        v = rsp_data;
    endtask

    task automatic pop_chk(input string req, input logic [7:0] exp);
        chk({req, " out_valid"}, 32'(out_valid), 32'd1);
        chk({req, " out_data"}, 32'(out_data), 32'(exp));
        out_pop = 1'b1;
        @(negedge clk);
        out_pop = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] v, p0, c0, i0, c1, i1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 running", 32'(stat_running), 0);
        chk("R1 cause", 32'(stat_cause), 0);
        chk("R1 core_en", 32'(core_en), 0);
        chk("R1 rsp_valid", 32'(rsp_valid), 0);
        chk("R1 out_valid", 32'(out_valid), 0);
        rd("R1", C_RCYC, 0, v); chk("R1 cycles", v, 0);
        rd("R1", C_RINS, 0, v); chk("R1 instrs", v, 0);

        // R4 PC write and read while halted
        cmd(C_WRPC, 32'h200);
        rd("R4", C_RDPC, 0, v); chk("R4 pc", v, 32'h200);

        // R5 register sweep
        for (int r = 0; r < 32; r++) begin
            cmd(C_RREQ, 32'(r));
            rd("R5", C_RGET, 0, v);
            chk("R5 reg", v, 32'hC0DE_0000 + 32'(r) * 32'd3);
        end

        // R6 memory reads
        for (int a = 0; a < 8; a++) begin
            rd("R6", C_RMEM, 32'h1000 + 32'(a) * 32'h44, v);
            chk("R6 mem", v, ~(32'h1000 + 32'(a) * 32'h44));
        end

        // R3 step sweep, R7 deltas
        for (int n = 0; n <= 6; n++) begin
            rd("R3", C_RDPC, 0, p0);
            rd("R7", C_RCYC, 0, c0);
            rd("R7", C_RINS, 0, i0);
            cmd(C_STEP, 32'(n));
            repeat (n + 3) @(negedge clk);
            chk("R3 halted", 32'(stat_running), 0);
            if (n > 0) chk("R3 cause", 32'(stat_cause), 2);
            rd("R3", C_RDPC, 0, v); chk("R3 pc", v, p0 + 32'(4 * n));
            rd("R7", C_RCYC, 0, c1); chk("R7 cyc delta", (c1 - c0) & 32'hFF, 32'(n));
            rd("R7", C_RINS, 0, i1); chk("R3 ins delta", (i1 - i0) & 32'hFF, 32'(n));
        end

        // R3 step with bubbles counts retires, not cycles
        bub_mode = 1'b1;
        rd("R3", C_RDPC, 0, p0);
        rd("R3", C_RINS, 0, i0);
        cmd(C_STEP, 5);
        repeat (20) @(negedge clk);
        bub_mode = 1'b0;
        chk("R3 bub cause", 32'(stat_cause), 2);
        rd("R3", C_RDPC, 0, v); chk("R3 bub pc", v, p0 + 20);
        rd("R3", C_RINS, 0, i1); chk("R3 bub ins", (i1 - i0) & 32'hFF, 5);

        // R2 start/stop, R7 deltas
        rd("R2", C_RCYC, 0, c0);
        rd("R2", C_RINS, 0, i0);
        cmd(C_START, 0);
        chk("R2 running", 32'(stat_running), 1);
        chk("R2 core_en", 32'(core_en), 1);
        repeat (10) @(negedge clk);
        cmd(C_STOP, 0);
        chk("R2 halted", 32'(stat_running), 0);
        chk("R2 cause", 32'(stat_cause), 1);
        rd("R7", C_RCYC, 0, c1); chk("R7 cyc run", (c1 - c0) & 32'hFF, 11);
        rd("R7", C_RINS, 0, i1); chk("R7 ins run", (i1 - i0) & 32'hFF, 11);

        // R4 R5 R6 ignored while running
        cmd(C_RREQ, 32'd31);
        rd("R4", C_RDPC, 0, p0);
        cmd(C_START, 0);
        cmd(C_WRPC, 32'h999);
        cmd(C_RREQ, 32'd3);
        cmd(C_RMEM, 32'h40);
        chk("R6 no rsp running", 32'(rsp_valid), 0);
        cmd(C_STOP, 0);
        rd("R4", C_RDPC, 0, v); chk("R4 wr ignored", v, p0 + 16);
        rd("R5", C_RGET, 0, v); chk("R5 req ignored", v, 32'hC0DE_0000 + 32'd93);

        // R8 breakpoint
        rd("R8", C_RDPC, 0, p0);
        rd("R8", C_RINS, 0, i0);
        cmd(C_SETBP, p0 + 12);
        cmd(C_START, 0);
        repeat (10) @(negedge clk);
        chk("R8 halted", 32'(stat_running), 0);
        chk("R8 cause", 32'(stat_cause), 3);
        rd("R8", C_RDPC, 0, v); chk("R8 pc", v, p0 + 12);
        rd("R8", C_RINS, 0, i1); chk("R8 ins", (i1 - i0) & 32'hFF, 3);
        // R9 restart from breakpoint
        cmd(C_START, 0);
        repeat (2) @(negedge clk);
        cmd(C_STOP, 0);
        rd("R9", C_RDPC, 0, v); chk("R9 start past bp", v, p0 + 24);
        cmd(C_SETBP, p0 + 24);
        cmd(C_STEP, 2);
        repeat (5) @(negedge clk);
        chk("R9 step cause", 32'(stat_cause), 2);
        rd("R9", C_RDPC, 0, v); chk("R9 step past bp", v, p0 + 32);
        // R8 disarm
        cmd(C_SETBP, p0 + 36);
        cmd(C_CLRBP, 0);
        cmd(C_STEP, 3);
        repeat (6) @(negedge clk);
        chk("R8 clr cause", 32'(stat_cause), 2);
        rd("R8", C_RDPC, 0, v); chk("R8 clr pc", v, p0 + 44);
        // R8 breakpoint during step
        cmd(C_SETBP, p0 + 48);
        cmd(C_STEP, 5);
        repeat (8) @(negedge clk);
        chk("R8 step bp cause", 32'(stat_cause), 3);
        rd("R8", C_RDPC, 0, v); chk("R8 step bp pc", v, p0 + 48);
        cmd(C_CLRBP, 0);

        // R10 full FIFO stalls, R11 order
        print_on = 1'b1;
        rd("R10", C_RDPC, 0, p0);
        rd("R10", C_RCYC, 0, c0);
        rd("R10", C_RINS, 0, i0);
        cmd(C_START, 0);
        repeat (6) @(negedge clk);
        chk("R10 running", 32'(stat_running), 1);
        chk("R10 stalled", 32'(core_en), 0);
        repeat (4) @(negedge clk);
        cmd(C_STOP, 0);
        rd("R10", C_RCYC, 0, c1); chk("R10 cyc", (c1 - c0) & 32'hFF, 11);
        rd("R10", C_RINS, 0, i1); chk("R10 ins", (i1 - i0) & 32'hFF, 4);
        for (int k = 0; k < 4; k++) pop_chk("R11", 8'((p0 >> 2) + 32'(k)));
        chk("R11 empty", 32'(out_valid), 0);

        // R10 pop releases one retire
        rd("R10", C_RDPC, 0, p0);
        cmd(C_START, 0);
        repeat (8) @(negedge clk);
        pop_chk("R11", 8'(p0 >> 2));
        repeat (4) @(negedge clk);
        cmd(C_STOP, 0);
        rd("R10", C_RDPC, 0, v); chk("R10 release pc", v, p0 + 20);
        for (int k = 1; k < 5; k++) pop_chk("R11", 8'((p0 >> 2) + 32'(k)));
        print_on = 1'b0;

        // R7 wrap of 8-bit counters
        rd("R7", C_RCYC, 0, c0);
        rd("R7", C_RINS, 0, i0);
        cmd(C_START, 0);
        repeat (299) @(negedge clk);
        cmd(C_STOP, 0);
        rd("R7", C_RCYC, 0, c1); chk("R7 cyc wrap", (c1 - c0) & 32'hFF, 44);
        rd("R7", C_RINS, 0, i1); chk("R7 ins wrap", (i1 - i0) & 32'hFF, 44);
        chk("R7 cyc width", c1 & 32'hFFFF_FF00, 0);

        finish_run();
    end

endmodule